// File: doc/BRIEF.md
# Paged Serial Configuration Stream Reader

This block is the read side of a serial configuration store. It presents one stored bit at a time on a serial output for a downstream device that is loading its configuration. Each rising clock edge moves an internal bit pointer forward, but only while the block is selected, not held in clear, and in streaming mode. A single active-low clear/enable pin does two jobs. While it is low, the pointer returns to zero on clock edges and the output floats.

The store can be read in one of two ways. It can be read as one contiguous image. It can also be split into four equal pages, with two select pins naming the page, so that one part can hold several alternative images. When the pointer reaches the end of the active region it stops and keeps presenting the last bit. It then pulls an active-low cascade flag so that a following store can take over the stream. While the mode pin is low the block is in programming mode: the read path is idle, and a simple synchronous write port fills the bit array.

Top module: `cfg_stream_reader`

## Requirements
- R1: With `oe_rst_n`=1, `ce_n`=0 and `ser_en`=1, each rising clock edge advances the read pointer by exactly one bit, until the end of the active region.
- R2: On every rising edge with `oe_rst_n`=0 the pointer clears to the region start and `ceo_n` returns to 1. While `oe_rst_n`=0, `dout_oe` is 0.
- R3: `dout_oe` is 1 only when `oe_rst_n`=1, `ce_n`=0 and `ser_en`=1. Whenever `dout_oe` is 0, `dout` reads 0.
- R4: With `ser_en`=1 and `ce_n`=1 (standby) the output floats and the pointer holds. Streaming resumes at the same bit.
- R5: With `ser_en`=0 (programming) the output floats and the pointer holds. A rising edge with `wr_en`=1 stores `wr_data` at bit address `wr_addr`.
- R6: Writes presented while `ser_en`=1 leave the array unchanged.
- R7: With paging off, the stream starts at bit address 0 and presents stored bit `a` as its a-th bit, through address DEPTH-1. After that it holds the last bit.
- R8: With paging on, the stream starts at address `page_sel`*DEPTH/4 and presents DEPTH/4 bits. It then holds the page's last bit and does not move into the next page.
- R9: `page_en` and `page_sel` are captured on the last rising edge with `oe_rst_n`=0. Later changes to them do not alter the stream until the next clear.
- R10: `ceo_n` falls on the rising edge that consumes the last bit of the active region, and stays 0 until the next clear.
- R11: The bit at the pointer reaches `dout` combinationally. After `oe_rst_n` rises, the first bit of the region is valid before any further clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, rising edge active |
| oe_rst_n | input | 1 | Active-low synchronous pointer clear and output float |
| ce_n | input | 1 | Active-low chip select; the pointer advances only while low |
| ser_en | input | 1 | 1 = streaming/standby, 0 = programming |
| page_en | input | 1 | 1 = four-page mode, captured during clear |
| page_sel | input | 2 | Page number, captured during clear |
| wr_en | input | 1 | Array write strobe, honoured only in programming mode |
| wr_addr | input | $clog2(DEPTH) | Bit address for the write port |
| wr_data | input | 1 | Bit value to store |
| dout | output | 1 | Serial data, 0 while floated |
| dout_oe | output | 1 | High when `dout` should be driven onto the line |
| ceo_n | output | 1 | Active-low cascade flag, low after the final bit |

## Verification
The bench streams a full unpaged image and each of the four pages. It checks the last bit and the edges after it, so a pointer that wraps or runs into the next page shows the wrong bit, and a cascade flag that fires one edge early or late is caught. Page pins are changed mid-stream: a design that decodes them live instead of capturing them jumps to another page. Standby and programming pauses are inserted mid-stream, so a pointer that keeps counting while paused resumes at the wrong bit. A write attempted during streaming is followed by a read of that bit, which exposes a write port that is not gated by the mode. The first bit is checked right after the clear is released, which catches a design that adds a register stage on the output.

// File: rtl/cfg_rd_pkg.sv
package cfg_rd_pkg;

    typedef enum logic [1:0] {
        RM_CLEAR    = 2'd0,
        RM_PROGRAM  = 2'd1,
        RM_STANDBY  = 2'd2,
        RM_STREAM   = 2'd3
    } rd_mode_e;

    // Priority: clear beats programming beats standby
    function automatic rd_mode_e mode_of(logic oe_rst_n, logic ce_n, logic ser_en);
        rd_mode_e m;
        if (!oe_rst_n)      m = RM_CLEAR;
        else if (!ser_en)   m = RM_PROGRAM;
        else if (ce_n)      m = RM_STANDBY;
        else                m = RM_STREAM;
        return m;
    endfunction

endpackage

// File: rtl/cfg_bit_store.sv
module cfg_bit_store #(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic          wdata,
    input  logic [AW-1:0] raddr,
    output logic          rbit
);

    logic [DEPTH-1:0] bits_d, bits_q;

    always_comb begin
        bits_d = bits_q;
        if (we) begin
            bits_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        bits_q <= bits_d;
    end

    // asynchronous read: the current bit follows the pointer directly
    assign rbit = bits_q[raddr];

endmodule

// File: rtl/cfg_addr_gen.sv
module cfg_addr_gen
    import cfg_rd_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW - 2
) (
    input  logic          clk,
    input  logic          oe_rst_n,
    input  logic          ce_n,
    input  logic          ser_en,
    input  logic          page_en,
    input  logic [1:0]    page_sel,
    output logic [AW-1:0] rd_addr,
    output logic          last_done
);

    typedef struct packed {
        logic [AW-1:0] cnt;
        logic [1:0]    page;
        logic          paged;
        logic          done;
    } ag_state_t;

    ag_state_t st_d, st_q;
    rd_mode_e  mode;
    logic      at_end;

    always_comb begin
        mode   = mode_of(oe_rst_n, ce_n, ser_en);
        at_end = st_q.paged ? (st_q.cnt[PW-1:0] == '1) : (st_q.cnt == '1);
        st_d   = st_q;
        case (mode)
            RM_CLEAR: begin
                st_d.cnt   = '0;
                st_d.page  = page_sel;
                st_d.paged = page_en;
                st_d.done  = 1'b0;
            end
            RM_STREAM: begin
                if (at_end) begin
                    st_d.done = 1'b1;
                end else begin
                    st_d.cnt  = st_q.cnt + 1'b1;
                end
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rd_addr   = st_q.paged ? {st_q.page, st_q.cnt[PW-1:0]} : st_q.cnt;
    assign last_done = st_q.done;

    p_step_r1: assert property (@(posedge clk) disable iff (!oe_rst_n)
        (ser_en && !ce_n && !last_done) |=> (last_done || rd_addr == AW'($past(rd_addr) + 1'b1)));

    p_hold_idle_r4: assert property (@(posedge clk) disable iff (!oe_rst_n)
        (!ser_en || ce_n) |=> $stable(rd_addr));

    p_stop_at_end_r8: assert property (@(posedge clk) disable iff (!oe_rst_n)
        last_done |=> $stable(rd_addr));

    p_page_lock_r9: assert property (@(posedge clk) disable iff (!oe_rst_n)
        st_q.paged |=> rd_addr[AW-1 -: 2] == $past(rd_addr[AW-1 -: 2]));

    p_cascade_sticky_r10: assert property (@(posedge clk) disable iff (!oe_rst_n)
        last_done |=> last_done);

endmodule

// File: rtl/cfg_out_stage.sv
module cfg_out_stage
    import cfg_rd_pkg::*;
(
    input  logic clk,
    input  logic oe_rst_n,
    input  logic ce_n,
    input  logic ser_en,
    input  logic bit_in,
    output logic dout,
    output logic dout_oe
);

    rd_mode_e mode;

    always_comb begin
        mode    = mode_of(oe_rst_n, ce_n, ser_en);
        dout_oe = (mode == RM_STREAM);
        dout    = dout_oe ? bit_in : 1'b0;
    end

    p_float_in_clear_r2: assert property (@(posedge clk)
        !oe_rst_n |-> !dout_oe);

    p_drive_needs_select_r3: assert property (@(posedge clk)
        dout_oe |-> (!ce_n && ser_en && oe_rst_n));

    p_quiet_when_floated_r3: assert property (@(posedge clk)
        !dout_oe |-> !dout);

endmodule

// File: rtl/cfg_stream_reader.sv
module cfg_stream_reader #(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          oe_rst_n,
    input  logic          ce_n,
    input  logic          ser_en,
    input  logic          page_en,
    input  logic [1:0]    page_sel,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_data,
    output logic          dout,
    output logic          dout_oe,
    output logic          ceo_n
);

    logic [AW-1:0] rd_addr;
    logic          cur_bit;
    logic          last_done;
    logic          store_we;

    // the array only accepts writes in programming mode (R6)
    assign store_we = wr_en & ~ser_en;

    cfg_bit_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (store_we),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rbit  (cur_bit)
    );

    cfg_addr_gen #(.DEPTH(DEPTH)) u_addr (
        .clk       (clk),
        .oe_rst_n  (oe_rst_n),
        .ce_n      (ce_n),
        .ser_en    (ser_en),
        .page_en   (page_en),
        .page_sel  (page_sel),
        .rd_addr   (rd_addr),
        .last_done (last_done)
    );

    cfg_out_stage u_out (
        .clk      (clk),
        .oe_rst_n (oe_rst_n),
        .ce_n     (ce_n),
        .ser_en   (ser_en),
        .bit_in   (cur_bit),
        .dout     (dout),
        .dout_oe  (dout_oe)
    );

    assign ceo_n = ~last_done;

    p_cascade_cleared_r2: assert property (@(posedge clk)
        !oe_rst_n |=> ceo_n);

endmodule

// File: tb/test_cfg_stream_reader.sv
`timescale 1ns/1ps
module test_cfg_stream_reader;

    localparam int DEPTH = 256;
    localparam int AW    = $clog2(DEPTH);
    localparam int Q     = DEPTH / 4;

    logic          clk = 1'b0;
    logic          oe_rst_n = 1'b0;
    logic          ce_n = 1'b1;
    logic          ser_en = 1'b0;
    logic          page_en = 1'b0;
    logic [1:0]    page_sel = 2'd0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic          wr_data = 1'b0;
    logic          dout, dout_oe, ceo_n;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    cfg_stream_reader #(.DEPTH(DEPTH)) i_cfg_stream_reader (
        .clk(clk), .oe_rst_n(oe_rst_n), .ce_n(ce_n), .ser_en(ser_en),
        .page_en(page_en), .page_sel(page_sel), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .dout(dout), .dout_oe(dout_oe), .ceo_n(ceo_n)
    );

    function automatic logic pat(int a);
        logic [7:0] v;
        v = 8'(a * 29 + 11);
        return ^v;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply_reset(logic pen, logic [1:0] psel);
        @(negedge clk);
        oe_rst_n = 1'b0; ser_en = 1'b1; ce_n = 1'b0; wr_en = 1'b0;
        page_en = pen; page_sel = psel;
        repeat (2) @(negedge clk);
        #1;
        check("R2 oe low in clear", 32'(dout_oe), 0);
        check("R2 dout quiet in clear", 32'(dout), 0);
        check("R2 ceo_n high in clear", 32'(ceo_n), 1);
    endtask

    // releases clear at a falling edge; first bit checked before any rising edge (R11)
    task automatic release_rst(int first, string req);
        @(negedge clk);
        oe_rst_n = 1'b1;
        #1;
        check({req, " R11 first bit before edge"}, 32'(dout), 32'(pat(first)));
    endtask

    task automatic run_bits(int start, int n, string req);
        for (int i = 0; i < n; i++) begin
            check({req, " R1 bit"}, 32'(dout), 32'(pat(start + i)));
            check({req, " R10 ceo early"}, 32'(ceo_n), 1);
            @(negedge clk);
        end
    endtask

    task automatic check_end(int last, string req);
        check({req, " R10 ceo after last"}, 32'(ceo_n), 0);
        check({req, " hold last bit"}, 32'(dout), 32'(pat(last)));
        repeat (3) @(negedge clk);
        check({req, " R10 ceo sticky"}, 32'(ceo_n), 0);
        check({req, " hold last bit later"}, 32'(dout), 32'(pat(last)));
    endtask

    // R5: fill the array in programming mode; read path must float and hold
    task automatic t_load;
        @(negedge clk);
        oe_rst_n = 1'b0; ser_en = 1'b0; ce_n = 1'b0;
        repeat (2) @(negedge clk);
        oe_rst_n = 1'b1;
        for (int a = 0; a < DEPTH; a++) begin
            wr_en = 1'b1; wr_addr = AW'(a); wr_data = pat(a);
            @(negedge clk);
            if (a == 5) check("R5 floated while programming", 32'(dout_oe), 0);
        end
        wr_en = 1'b0;
        ser_en = 1'b1;
        #1;
        check("R5 pointer held through programming", 32'(dout), 32'(pat(0)));
        check("R3 driven when streaming", 32'(dout_oe), 1);
    endtask

    task automatic t_unpaged;
        apply_reset(1'b0, 2'd3);
        release_rst(0, "R7");
        run_bits(0, DEPTH, "R7 full image");
        check_end(DEPTH - 1, "R7");
    endtask

    task automatic t_paged;
        for (int p = 0; p < 4; p++) begin
            apply_reset(1'b1, 2'(p));
            release_rst(p * Q, "R8");
            run_bits(p * Q, 20, "R8 page head");
            page_sel = 2'(p ^ 1);
            page_en  = 1'b0;
            run_bits(p * Q + 20, Q - 20, "R9 pins changed mid-read");
            check_end(p * Q + Q - 1, "R8 page end");
        end
    endtask

    task automatic t_standby;
        apply_reset(1'b0, 2'd0);
        release_rst(0, "R4");
        run_bits(0, 5, "R4 pre");
        ce_n = 1'b1;
        #1;
        check("R3 floated when deselected", 32'(dout_oe), 0);
        check("R3 dout quiet when deselected", 32'(dout), 0);
        repeat (4) @(negedge clk);
        ce_n = 1'b0;
        #1;
        check("R4 resumes at held bit", 32'(dout), 32'(pat(5)));
        run_bits(5, 3, "R4 post");
    endtask

    task automatic t_prog_pause;
        apply_reset(1'b0, 2'd0);
        release_rst(0, "R5");
        run_bits(0, 9, "R5 pre");
        ser_en = 1'b0;
        #1;
        check("R5 floated in programming", 32'(dout_oe), 0);
        check("R3 dout quiet in programming", 32'(dout), 0);
        repeat (3) @(negedge clk);
        ser_en = 1'b1;
        #1;
        check("R5 resumes at held bit", 32'(dout), 32'(pat(9)));
        run_bits(9, 2, "R5 post");
    endtask

    task automatic t_write_ignored;
        apply_reset(1'b0, 2'd0);
        @(negedge clk);
        oe_rst_n = 1'b1; ce_n = 1'b1;
        wr_en = 1'b1; wr_addr = AW'(3); wr_data = ~pat(3);
        @(negedge clk);
        wr_en = 1'b0; ce_n = 1'b0;
        #1;
        run_bits(0, 4, "R6 write ignored in stream mode");
    endtask

    task automatic t_clear_mid;
        apply_reset(1'b1, 2'd2);
        release_rst(2 * Q, "R2");
        run_bits(2 * Q, 10, "R2 pre");
        oe_rst_n = 1'b0;
        #1;
        check("R2 float at once on clear", 32'(dout_oe), 0);
        @(negedge clk);
        oe_rst_n = 1'b1;
        #1;
        check("R2 pointer back at page start", 32'(dout), 32'(pat(2 * Q)));
    endtask

    initial begin
        t_load;
        t_unpaged;
        t_paged;
        t_standby;
        t_prog_pause;
        t_write_ignored;
        t_clear_mid;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R1 actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule